// File: doc/BRIEF.md
# 802.15.4 PHY Frame Serializer

This block turns a payload handed over by the MAC side into the byte stream of a complete PHY protocol data unit, ahead of the symbol spreader. A one-cycle start pulse carries a 7-bit payload length. The block then emits a synchronization header, which is a run of zero-valued preamble bytes followed by the start-of-frame delimiter. It emits a header byte carrying the length next, and after that the payload bytes, which it takes from a valid/ready input port and passes through unchanged.

The output is a valid/ready byte stream. A last flag marks the final payload byte. The block does not compute a checksum, so the payload that arrives must already hold one if the frame needs it. A start request with a length of zero produces no frame and raises a one-cycle error pulse. Start requests that arrive while a frame is being sent are ignored.

Top module: `phy_frame_serializer`

## Requirements
- R1: While in reset and after it, with no start request, `out_valid_o`, `in_ready_o`, `out_last_o` and `err_o` are all 0.
- R2: A start pulse with a nonzero length makes the first output byte valid in the next cycle. The frame opens with `PRE_BYTES` (default 4) bytes of value 0x00.
- R3: The byte that follows the preamble is the start-of-frame delimiter 0xA7. Transmitted LSB first, its bits read 1,1,1,0,0,1,0,1.
- R4: The byte after the delimiter is the header byte. Bits 6:0 hold the payload length latched at the start pulse, and bit 7 is 0.
- R5: After the header byte, exactly `len` payload bytes are forwarded unchanged and in order. `in_ready_o` is 1 only during the payload phase, and only while `out_ready_i` is 1.
- R6: `out_last_o` is 1 only together with the final payload byte. In the cycle after that byte is accepted, `out_valid_o` is 0.
- R7: A start pulse with length 0 gives `err_o` = 1 in the following cycle only, and no output byte is produced.
- R8: A start pulse that arrives while a frame is in progress is ignored. The current frame keeps its length and contents, and no new frame follows it.
- R9: While `out_ready_i` is 0 in the header phases, the offered byte stays valid and unchanged, and the sequence does not advance.
- R10: The largest length, 127, produces a complete frame of 127 payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle frame request |
| len_i | input | 7 | Payload byte count, sampled with start_i |
| in_valid_i | input | 1 | Payload byte available |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Payload byte accepted when in_valid_i is also 1 |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final payload byte of the frame |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| err_o | output | 1 | Zero-length request rejected |

## Verification
The assertions assume that the upstream source keeps `in_data_i` steady while it holds a byte offered and not yet taken. They also assume that `start_i` is a single-cycle pulse. Hold checks therefore cover only the header phases, where the block alone supplies the data. The bench drives every input on the falling edge. It advances the payload index only when it sees a handshake, so each payload byte remains valid until it is consumed. It sweeps every length from 1 to 127, alternating between a free-flowing pattern and a periodic stall pattern on both ports, and it injects zero-length and mid-frame start requests.

// File: rtl/phy_ser_pkg.sv
package phy_ser_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hA7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_PHR,
    ST_PAY
  } ser_state_e;
endpackage

// File: rtl/phy_ser_ctrl.sv
module phy_ser_ctrl
  import phy_ser_pkg::*;
#(
  parameter int PRE_BYTES = 4,
  parameter int LEN_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output ser_state_e       state_o,
  output logic [LEN_W-1:0] len_q_o,
  output logic             last_o,
  output logic             err_o
);
  localparam int PRE_W = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_BYTES - 1);

  ser_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [LEN_W-1:0] pay_cnt_q;
  logic             err_q;

  assign last_o  = (state_q == ST_PAY) && (pay_cnt_q == len_q - LEN_W'(1));
  assign state_o = state_q;
  assign len_q_o = len_q;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      pre_cnt_q <= '0;
      pay_cnt_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (len_i == '0) begin
            err_q <= 1'b1;
          end else begin
            len_q     <= len_i;
            pre_cnt_q <= '0;
            state_q   <= ST_PRE;
          end
        end
        ST_PRE: if (beat_i) begin
          if (pre_cnt_q == PRE_LAST) state_q <= ST_SFD;
          else pre_cnt_q <= pre_cnt_q + PRE_W'(1);
        end
        ST_SFD: if (beat_i) state_q <= ST_PHR;
        ST_PHR: if (beat_i) begin
          pay_cnt_q <= '0;
          state_q   <= ST_PAY;
        end
        ST_PAY: if (beat_i) begin
          if (last_o) state_q <= ST_IDLE;
          else pay_cnt_q <= pay_cnt_q + LEN_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // mid-frame start must not disturb the latched length
  p_len_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(len_q));

  p_zero_len_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && len_i == '0) |=> (err_q && state_q == ST_IDLE));

  p_err_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/phy_ser_mux.sv
module phy_ser_mux
  import phy_ser_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  ser_state_e        state_i,
  input  logic [LEN_W-1:0]  len_q_i,
  input  logic              last_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_last_o
);
  localparam int PAD_W = BYTE_W - LEN_W;

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    unique case (state_i)
      ST_PRE: out_valid_o = 1'b1;
      ST_SFD: begin
        out_valid_o = 1'b1;
        out_data_o  = SFD_BYTE;
      end
      ST_PHR: begin
        out_valid_o = 1'b1;
        out_data_o  = {{PAD_W{1'b0}}, len_q_i};
      end
      ST_PAY: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_last_o  = last_i;
        in_ready_o  = out_ready_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_frame_serializer.sv
module phy_frame_serializer
  import phy_ser_pkg::*;
#(
  parameter int PRE_BYTES = 4,
  parameter int LEN_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic             err_o
);
  ser_state_e       state;
  logic [LEN_W-1:0] len_q;
  logic             last;
  logic             beat;

  assign beat = out_valid_o && out_ready_i;

  phy_ser_ctrl #(.PRE_BYTES(PRE_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .len_i   (len_i),
    .beat_i  (beat),
    .state_o (state),
    .len_q_o (len_q),
    .last_o  (last),
    .err_o   (err_o)
  );

  phy_ser_mux #(.LEN_W(LEN_W)) u_mux (
    .state_i     (state),
    .len_q_i     (len_q),
    .last_i      (last),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );

  p_first_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && start_i && len_i != '0) |=> (out_valid_o && out_data_o == 8'h00));

  p_hdr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_PAY && out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_idle_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

  p_ready_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);

  p_phr_rsvd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SFD && beat) |=> (out_valid_o && !out_data_o[7]));
endmodule

// File: tb/phy_frame_serializer_tb.sv
`timescale 1ns/1ps
module phy_frame_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] len = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last, err;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  phy_frame_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int l, input int k);
    return 8'((l * 7 + k * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(input int l, input int i);
    if (i < 4) return 8'h00;
    if (i == 4) return 8'hA7;
    if (i == 5) return {1'b0, 7'(l)};
    return pay(l, i - 6);
  endfunction

  task automatic run_frame(input int l, input int mode, input bit poke);
    int idx = 0;
    int kin = 0;
    int cyc = 0;
    bit done = 0;
    string req;
    @(negedge clk);
    start = 1'b1; len = 7'(l);
    @(negedge clk);
    start = 1'b0; len = 7'h55;
    while (!done && cyc < 3000) begin
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      in_valid  = (mode == 0) ? 1'b1 : ((cyc % 4) != 1);
      in_data   = pay(l, kin);
      start     = poke && (idx == 3 || idx == 8);
      len       = 7'(l ^ 3);
      #1;
      if (idx < 6) chk(in_ready == 1'b0, "R5 in_ready in header", in_ready, 0);
      if (out_valid) begin
        if (idx < 6 && !out_ready) req = "R9 stalled header byte";
        else if (idx < 4) req = "R2 preamble";
        else if (idx == 4) req = "R3 delimiter";
        else if (idx == 5) req = "R4 header";
        else req = (l == 127) ? "R10 payload" : "R5 payload";
        chk(out_data == exp_byte(l, idx), req, out_data, exp_byte(l, idx));
        if (out_ready)
          chk(out_last == (idx == l + 5), "R6 last flag", out_last, (idx == l + 5));
      end
      if (out_valid && out_ready) begin
        idx++;
        if (idx == l + 6) done = 1;
      end
      if (in_valid && in_ready) kin++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, "R2 frame completes", idx, l + 6);
    chk(kin == l, (l == 127) ? "R10 payload count" : "R5 payload count", kin, l);
    out_ready = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R6 idle after last", out_valid, 0);
    if (poke) begin
      repeat (2) begin
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R8 no restart", out_valid, 0);
      end
    end
  endtask

  task automatic zero_len;
    @(negedge clk);
    start = 1'b1; len = 7'd0;
    @(negedge clk);
    start = 1'b0; len = 7'd9;
    #1;
    chk(err == 1'b1, "R7 err pulse", err, 1);
    chk(out_valid == 1'b0, "R7 no output", out_valid, 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk(err == 1'b0, "R7 err one cycle", err, 0);
      chk(out_valid == 1'b0, "R7 no frame", out_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0 && in_ready == 0 && err == 0 && out_last == 0,
        "R1 in reset", {out_valid, in_ready, err, out_last}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 0 && in_ready == 0 && err == 0 && out_last == 0,
        "R1 after reset", {out_valid, in_ready, err, out_last}, 0);
    zero_len();
    for (int l = 1; l <= 127; l++) begin
      run_frame(l, l % 2, (l % 5) == 0);
      if (l == 64) zero_len();
    end
    run_frame(127, 0, 1'b1);
    run_frame(1, 1, 1'b1);
    zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule